// File: doc/BRIEF.md
# Image Sensor Readout Timing Generator

This block walks a windowed pixel array in raster order. Each row has its active columns followed by a horizontal blanking interval. Each frame has its active rows followed by vertical blanking rows. The block drives the row and column addresses for the array and produces four strobes: line-valid, frame-valid, a frame-start pulse and a frame-boundary pulse.

The frame-boundary pulse marks the single cycle at which a register bank may commit new settings. The generator also latches its own copy of the configuration at that cycle, so the geometry cannot change in the middle of a frame. The frame grows by itself when the requested exposure (shutter width, in rows) needs more rows than the window and vertical blanking provide. Dropping the enable parks the generator. Raising it again starts a fresh frame at the first row.

Top module: `sensor_readout_timer`

## Requirements
- R1: While reset is asserted, and while parked with `en_i` low, `line_valid_o`, `frame_valid_o`, `frame_start_o` and `frame_bound_o` are all 0. While parked with `en_i` high, `frame_bound_o` is 1.
- R2: The cycle after a `frame_bound_o` cycle has `frame_start_o`=1 for exactly that one cycle, with `row_addr_o`=first row and `col_addr_o`=first column.
- R3: Each row lasts width+1+hblank cycles. `line_valid_o` is 1 for the first width+1 cycles of an active row, with `col_addr_o` = first column + cycle index, and 0 for the hblank cycles.
- R4: `frame_valid_o` is 1 for the first height+1 rows of a frame and 0 for the rest. During those rows `row_addr_o` = first row + row index, modulo 2^RW.
- R5: With a small shutter width, a frame has height + vblank + 2 rows.
- R6: With `full_shutter_i`=0, a frame has max(height+vblank+2, shutter+1) rows.
- R7: With `full_shutter_i`=1, a frame has max(height+vblank+2, shutter) rows.
- R8: Configuration inputs are latched only at a `frame_bound_o` cycle. Changes made at any other time have no effect on the frame in progress.
- R9: If `en_i` is 0 at a clock edge, the generator is parked from the next cycle with all strobes 0. When `en_i` returns to 1, `frame_bound_o` rises at once, and the following cycle begins a new frame at the first row.
- R10: `frame_bound_o` is 1 for one cycle, in the last cycle of the last row of each frame, so frame starts are total_rows × row_length cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Readout enable |
| full_shutter_i | input | 1 | 1: shutter may span the whole frame |
| first_row_i | input | RW | First row address of the window |
| first_col_i | input | CW | First column address of the window |
| win_height_i | input | RW | Window rows minus one |
| win_width_i | input | CW | Window columns minus one |
| hblank_i | input | HBW | Blanking cycles appended to each row |
| vblank_i | input | VBW | Vertical blanking rows minus one |
| shutter_i | input | SW | Shutter width in rows |
| row_addr_o | output | RW | Current row address |
| col_addr_o | output | CW | Current column address |
| line_valid_o | output | 1 | Active pixel in an active row |
| frame_valid_o | output | 1 | Inside the active rows |
| frame_start_o | output | 1 | First cycle of a frame |
| frame_bound_o | output | 1 | Last cycle of a frame; configuration is committed here |

## Verification
The assertions check the following on every cycle:
- line-valid is contained in frame-valid;
- a boundary cycle is followed by a start cycle, and is never followed by another boundary cycle;
- a low enable leads to silent outputs;
- the counters stay within their limits;
- the latched settings hold between boundaries;
- a frame is always longer than its window.

Other properties need the bench's frame walks, which check every cycle of several frames against arithmetic expectations. These cover:
- the exact row and column address sequences;
- the blanking lengths;
- the frame stretch under each shutter mode, including the case where the shutter exactly equals the base row count;
- the restart position after the enable is dropped.

// File: rtl/rdo_pkg.sv
`timescale 1ns/1ps
package rdo_pkg;
  typedef enum logic {ST_PARK = 1'b0, ST_RUN = 1'b1} rdo_state_e;

  function automatic int unsigned wmax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rdo_counter.sv
`timescale 1ns/1ps
module rdo_counter #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = inc_i && (cnt_q == last_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + W'(1);
  end

  p_cnt_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i);
endmodule

// File: rtl/rdo_shadow.sv
`timescale 1ns/1ps
module rdo_shadow #(
  parameter int RW  = 9,
  parameter int CW  = 10,
  parameter int HBW = 10,
  parameter int VBW = 12,
  parameter int SW  = 12,
  parameter int TW  = 14
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cap_i,
  input  logic           full_shutter_i,
  input  logic [RW-1:0]  first_row_i,
  input  logic [CW-1:0]  first_col_i,
  input  logic [RW-1:0]  height_i,
  input  logic [CW-1:0]  width_i,
  input  logic [HBW-1:0] hblank_i,
  input  logic [VBW-1:0] vblank_i,
  input  logic [SW-1:0]  shutter_i,
  output logic [RW-1:0]  first_row_o,
  output logic [CW-1:0]  first_col_o,
  output logic [RW-1:0]  height_o,
  output logic [CW-1:0]  width_o,
  output logic [HBW-1:0] hblank_o,
  output logic [TW-1:0]  total_rows_o
);
  logic [TW-1:0] base_rows, shut_rows, total_d;

  // window rows + blanking rows, both fields are stored minus one
  assign base_rows = TW'(height_i) + TW'(vblank_i) + TW'(2);
  assign shut_rows = TW'(shutter_i) + TW'(!full_shutter_i);
  assign total_d   = (shut_rows > base_rows) ? shut_rows : base_rows;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_row_o  <= '0;
      first_col_o  <= '0;
      height_o     <= '0;
      width_o      <= '0;
      hblank_o     <= '0;
      total_rows_o <= '0;
    end else if (cap_i) begin
      first_row_o  <= first_row_i;
      first_col_o  <= first_col_i;
      height_o     <= height_i;
      width_o      <= width_i;
      hblank_o     <= hblank_i;
      total_rows_o <= total_d;
    end
  end

  p_hold_between_bounds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> ($stable(width_o) && $stable(height_o) && $stable(total_rows_o)
                && $stable(first_row_o) && $stable(first_col_o) && $stable(hblank_o)));

  p_frame_exceeds_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (total_rows_o > TW'(height_o) + TW'(1)));
endmodule

// File: rtl/sensor_readout_timer.sv
`timescale 1ns/1ps
module sensor_readout_timer
  import rdo_pkg::*;
#(
  parameter int RW  = 9,
  parameter int CW  = 10,
  parameter int HBW = 10,
  parameter int VBW = 12,
  parameter int SW  = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           full_shutter_i,
  input  logic [RW-1:0]  first_row_i,
  input  logic [CW-1:0]  first_col_i,
  input  logic [RW-1:0]  win_height_i,
  input  logic [CW-1:0]  win_width_i,
  input  logic [HBW-1:0] hblank_i,
  input  logic [VBW-1:0] vblank_i,
  input  logic [SW-1:0]  shutter_i,
  output logic [RW-1:0]  row_addr_o,
  output logic [CW-1:0]  col_addr_o,
  output logic           line_valid_o,
  output logic           frame_valid_o,
  output logic           frame_start_o,
  output logic           frame_bound_o
);
  localparam int CTW = int'(wmax(CW, HBW)) + 1;
  localparam int TW  = int'(wmax(wmax(RW, VBW), SW)) + 2;

  rdo_state_e     state_q;
  logic [RW-1:0]  sh_first_row, sh_height;
  logic [CW-1:0]  sh_first_col, sh_width;
  logic [HBW-1:0] sh_hblank;
  logic [TW-1:0]  sh_total;
  logic [CTW-1:0] col_cnt, col_last;
  logic [TW-1:0]  row_cnt, row_last;
  logic           col_wrap, frame_last, run, cnt_clr;

  assign run           = (state_q == ST_RUN);
  assign frame_bound_o = en_i && (!run || frame_last);
  assign cnt_clr       = frame_bound_o || !run;
  assign col_last      = CTW'(sh_width) + CTW'(sh_hblank);
  assign row_last      = sh_total - TW'(1);

  rdo_shadow #(
    .RW(RW), .CW(CW), .HBW(HBW), .VBW(VBW), .SW(SW), .TW(TW)
  ) u_shadow (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cap_i          (frame_bound_o),
    .full_shutter_i (full_shutter_i),
    .first_row_i    (first_row_i),
    .first_col_i    (first_col_i),
    .height_i       (win_height_i),
    .width_i        (win_width_i),
    .hblank_i       (hblank_i),
    .vblank_i       (vblank_i),
    .shutter_i      (shutter_i),
    .first_row_o    (sh_first_row),
    .first_col_o    (sh_first_col),
    .height_o       (sh_height),
    .width_o        (sh_width),
    .hblank_o       (sh_hblank),
    .total_rows_o   (sh_total)
  );

  rdo_counter #(.W(CTW)) u_col (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (run),
    .last_i (col_last),
    .cnt_o  (col_cnt),
    .wrap_o (col_wrap)
  );

  rdo_counter #(.W(TW)) u_row (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (col_wrap),
    .last_i (row_last),
    .cnt_o  (row_cnt),
    .wrap_o (frame_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            state_q <= ST_PARK;
    else if (!en_i)         state_q <= ST_PARK;
    else if (frame_bound_o) state_q <= ST_RUN;
  end

  assign frame_valid_o = run && (row_cnt <= TW'(sh_height));
  assign line_valid_o  = frame_valid_o && (col_cnt <= CTW'(sh_width));
  assign frame_start_o = run && (row_cnt == '0) && (col_cnt == '0);
  assign row_addr_o    = sh_first_row + row_cnt[RW-1:0];
  assign col_addr_o    = sh_first_col + col_cnt[CW-1:0];

  p_lv_inside_fv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> frame_valid_o);

  p_start_after_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_bound_o |=> (frame_start_o && line_valid_o));

  p_bound_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_bound_o |=> !frame_bound_o);

  p_park_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!frame_valid_o && !line_valid_o && !frame_start_o));

  p_strobes_need_run_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> run);
endmodule

// File: tb/sensor_readout_timer_test.sv
`timescale 1ns/1ps
module sensor_readout_timer_test;
  localparam int RW = 9, CW = 10, HBW = 10, VBW = 12, SW = 12;

  typedef struct {
    int fr; int fc; int h; int w; int hb; int vb; int sh; int full;
  } cfg_t;

  logic clk = 1'b0, rst_ni = 1'b0, en = 1'b0, full_sh = 1'b0;
  logic [RW-1:0] first_row = '0, height = '0, row_addr;
  logic [CW-1:0] first_col = '0, width = '0, col_addr;
  logic [HBW-1:0] hblank = '0;
  logic [VBW-1:0] vblank = '0;
  logic [SW-1:0]  shutter = '0;
  logic lv, fv, fs, fb;

  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  sensor_readout_timer #(.RW(RW), .CW(CW), .HBW(HBW), .VBW(VBW), .SW(SW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .full_shutter_i(full_sh),
    .first_row_i(first_row), .first_col_i(first_col), .win_height_i(height),
    .win_width_i(width), .hblank_i(hblank), .vblank_i(vblank), .shutter_i(shutter),
    .row_addr_o(row_addr), .col_addr_o(col_addr), .line_valid_o(lv),
    .frame_valid_o(fv), .frame_start_o(fs), .frame_bound_o(fb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input cfg_t c);
    first_row = RW'(c.fr); first_col = CW'(c.fc); height = RW'(c.h); width = CW'(c.w);
    hblank = HBW'(c.hb); vblank = VBW'(c.vb); shutter = SW'(c.sh); full_sh = (c.full != 0);
  endtask

  function automatic int total_rows(input cfg_t c);
    int base = c.h + c.vb + 2;
    int shm  = c.sh + ((c.full != 0) ? 0 : 1);
    return (shm > base) ? shm : base;
  endfunction

  // Called at the negedge of a frame's first cycle; returns at the next frame's first cycle.
  // The next configuration is applied right after the first cycle (R8: must not affect this frame).
  task automatic walk(input cfg_t c, input cfg_t nx, input string len_req);
    int len = c.w + 1 + c.hb;
    int tot = total_rows(c);
    int e_lv = 0, e_fv = 0, e_fs = 0, e_fb = 0, e_row = 0, e_col = 0;
    int a_row = 0, x_row = 0, a_col = 0, x_col = 0, bound_at = -1;
    for (int i = 0; i < tot * len; i++) begin
      int r = i / len;
      int k = i % len;
      bit x_fv = (r <= c.h);
      bit x_lv = x_fv && (k <= c.w);
      if (i > 0) @(negedge clk);
      if (lv !== x_lv) e_lv++;
      if (fv !== x_fv) e_fv++;
      if (fs !== (i == 0)) e_fs++;
      if (fb === 1'b1) bound_at = i;
      if (fb !== (i == tot * len - 1)) e_fb++;
      if (x_fv && int'(row_addr) != ((c.fr + r) % (1 << RW))) begin
        e_row++; a_row = int'(row_addr); x_row = (c.fr + r) % (1 << RW);
      end
      if (x_lv && int'(col_addr) != ((c.fc + k) % (1 << CW))) begin
        e_col++; a_col = int'(col_addr); x_col = (c.fc + k) % (1 << CW);
      end
      if (i == 0) drive(nx);
    end
    chk(e_fs == 0, "R2 frame_start position", e_fs, 0);
    chk(e_lv == 0, "R3 line_valid pattern", e_lv, 0);
    chk(e_col == 0, "R3 column address", a_col, x_col);
    chk(e_fv == 0, "R4 frame_valid pattern", e_fv, 0);
    chk(e_row == 0, "R4 row address", a_row, x_row);
    chk(e_fb == 0, "R10 boundary single pulse", e_fb, 0);
    chk(bound_at == tot * len - 1, len_req, bound_at + 1, tot * len);
    chk(e_lv + e_fv + e_row + e_col == 0, "R8 frame kept latched geometry", e_lv + e_fv, 0);
    @(negedge clk);
    chk(fs === 1'b1, "R2 next frame starts", int'(fs), 1);
  endtask

  initial begin
    #(8 * 100000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    cfg_t ca, cb, cc, cd, ce;
    ca = '{fr: 10, fc: 22, h: 2, w: 3, hb: 2, vb: 1, sh: 0, full: 0};  // 5 rows
    cb = '{fr: 6, fc: 18, h: 1, w: 4, hb: 1, vb: 0, sh: 8, full: 0};   // 9 rows
    cc = '{fr: 6, fc: 18, h: 1, w: 4, hb: 1, vb: 0, sh: 8, full: 1};   // 8 rows
    cd = '{fr: 510, fc: 1020, h: 3, w: 2, hb: 0, vb: 2, sh: 7, full: 1}; // 7 rows, equal, wraps addr
    ce = '{fr: 0, fc: 0, h: 3, w: 2, hb: 3, vb: 2, sh: 6, full: 0};    // 7 rows, equal

    drive(ca);
    repeat (3) @(negedge clk);
    chk({lv, fv, fs, fb} == 4'b0, "R1 strobes in reset", int'({lv, fv, fs, fb}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk({lv, fv, fs, fb} == 4'b0, "R1 parked with enable low", int'({lv, fv, fs, fb}), 0);
    en = 1'b1;
    #1;
    chk(fb === 1'b1, "R1 parked boundary with enable high", int'(fb), 1);
    @(negedge clk);
    chk(fs === 1'b1 && int'(row_addr) == ca.fr && int'(col_addr) == ca.fc,
        "R2 first cycle addresses", int'(row_addr), ca.fr);

    walk(ca, cb, "R5 frame length base");
    walk(cb, cc, "R6 frame stretched to shutter+1");
    walk(cc, cd, "R7 frame stretched to shutter");
    walk(cd, ce, "R7 shutter equal to base rows");
    walk(ce, ca, "R6 shutter+1 equal to base rows");

    // R9: drop enable mid-frame
    repeat (7) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk({lv, fv, fs, fb} == 4'b0, "R9 parked after enable low", int'({lv, fv, fs, fb}), 0);
    repeat (3) @(negedge clk);
    chk({lv, fv, fs, fb} == 4'b0, "R9 stays parked", int'({lv, fv, fs, fb}), 0);
    en = 1'b1;
    #1;
    chk(fb === 1'b1, "R9 boundary on re-enable", int'(fb), 1);
    @(negedge clk);
    chk(fs === 1'b1 && int'(row_addr) == ca.fr, "R9 restart at first row", int'(row_addr), ca.fr);
    walk(ca, ca, "R9 full frame after restart");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule